// File: doc/BRIEF.md
# Pipeline hazard and bypass controller

This block is the combinational hazard logic of a five-stage in-order pipeline (fetch, decode, execute, memory, writeback). It chooses where each of the two execute-stage ALU operands comes from: the value read in decode, the result held in the memory stage, or the result held in writeback. It also decides whether the store-data value entering memory should be replaced by the writeback result. In decode it flags a register-file write-through for each read port.

The block also detects the single load-use hazard this pipeline has. When the instruction in execute is a load and the instruction in decode needs the loaded register as an execute-stage operand, it raises `stall_o` and `bubble_o`. The pipeline uses these to hold fetch and decode for one cycle and to push a no-operation into execute. On the next cycle the load has moved to the memory stage and the same comparison clears by itself. A store that needs the loaded value only as its data is not stalled, because that value reaches the memory stage through the writeback bypass.

Source register numbers, read flags and producer attributes arrive already decoded from the pipeline registers. Register-number width is a parameter.

Top module: `hz_ctrl`

## Requirements
- R1: `fwd_a_sel_o` selects the operand-A source for the execute instruction. It is 1 (memory stage) when `ex_rs_rd_i` is set and the memory-stage producer qualifies with `mem_rd_i == ex_rs_i`. Otherwise it is 2 (writeback) when the writeback producer qualifies with `wb_rd_i == ex_rs_i`. Otherwise it is 0 (register-file value). The value 3 never appears.
- R2: `fwd_b_sel_o` follows the same rule and encoding for operand B, using `ex_rt_i` and `ex_rt_rd_i`.
- R3: When the memory and writeback stages both qualify with the same destination, the memory stage (the younger producer) wins.
- R4: A producer qualifies only if both its valid bit and its write enable are set. A squashed or non-writing instruction is never forwarded.
- R5: A load in the memory stage (`mem_load_i`) is never forwarded to execute, because its data is not yet available.
- R6: `st_data_fwd_o` is 1 exactly when the memory-stage instruction reads a store-data register (`mem_st_rd_i`) and the qualifying writeback producer writes `mem_st_src_i`.
- R7: `wt_a_o` / `wt_b_o` are 1 exactly when the decode read flag for rs / rt is set and writeback is valid, write-enabled and targets that register. The decode read then takes the value being written.
- R8: `stall_o` is 1 exactly when the execute instruction is a valid, write-enabled load and its destination matches a decode source that is read in execute. Source rs counts when `dec_rs_rd_i` is set. Source rt counts when `dec_rt_rd_i` is set and `dec_rt_late_i` is clear. Non-load producers never stall.
- R9: A decode rt marked late (store data only) that matches an execute-stage load does not stall.
- R10: A source field whose read flag is clear never causes a stall, whatever its bits hold.
- R11: `bubble_o` always equals `stall_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| dec_rs_i | input | REG_W | Decode source rs number |
| dec_rs_rd_i | input | 1 | Decode reads rs |
| dec_rt_i | input | REG_W | Decode source rt number |
| dec_rt_rd_i | input | 1 | Decode reads rt |
| dec_rt_late_i | input | 1 | Decode rt is needed only in memory stage (store data) |
| ex_rs_i | input | REG_W | Execute source rs number |
| ex_rs_rd_i | input | 1 | Execute reads rs |
| ex_rt_i | input | REG_W | Execute source rt number |
| ex_rt_rd_i | input | 1 | Execute reads rt |
| ex_rd_i | input | REG_W | Execute destination |
| ex_we_i | input | 1 | Execute writes a register |
| ex_load_i | input | 1 | Execute instruction is a load |
| ex_vld_i | input | 1 | Execute instruction valid (not squashed) |
| mem_rd_i | input | REG_W | Memory-stage destination |
| mem_we_i | input | 1 | Memory-stage writes a register |
| mem_load_i | input | 1 | Memory-stage instruction is a load |
| mem_vld_i | input | 1 | Memory-stage instruction valid |
| mem_st_src_i | input | REG_W | Memory-stage store-data register |
| mem_st_rd_i | input | 1 | Memory-stage instruction reads store data |
| wb_rd_i | input | REG_W | Writeback destination |
| wb_we_i | input | 1 | Writeback writes a register |
| wb_vld_i | input | 1 | Writeback instruction valid |
| fwd_a_sel_o | output | 2 | Operand A source: 0 RF, 1 memory, 2 writeback |
| fwd_b_sel_o | output | 2 | Operand B source: 0 RF, 1 memory, 2 writeback |
| st_data_fwd_o | output | 1 | Replace store data with writeback result |
| wt_a_o | output | 1 | Decode rs read takes writeback value |
| wt_b_o | output | 1 | Decode rt read takes writeback value |
| stall_o | output | 1 | Hold fetch and decode this cycle |
| bubble_o | output | 1 | Insert no-operation into execute |

## Verification
A wrong priority or qualification inside this block shows up in the same cycle as a bad select code on `fwd_a_sel_o`, `fwd_b_sel_o` or `st_data_fwd_o`. In a full pipeline that becomes a stale operand one cycle later. A faulty stall comparison shows immediately as an extra or missing `stall_o`. An over-stall costs only cycles, so the bench probes every case where a register number matches but must not cause a stall: clear read flags, late store data, and non-load producers. Each scenario is applied on the ports and sampled after the logic settles. This catches any mismatch in the cycle in which it occurs.

// File: rtl/hz_pkg.sv
package hz_pkg;
  typedef enum logic [1:0] {
    SEL_RF  = 2'd0,
    SEL_MEM = 2'd1,
    SEL_WB  = 2'd2
  } fwd_sel_e;
endpackage

// File: rtl/hz_src_fwd.sv
module hz_src_fwd
  import hz_pkg::*;
#(
  parameter int REG_W = 3
) (
  input  logic [REG_W-1:0] src_i,
  input  logic             src_rd_i,
  input  logic             mem_ok_i,
  input  logic [REG_W-1:0] mem_rd_i,
  input  logic             wb_ok_i,
  input  logic [REG_W-1:0] wb_rd_i,
  output fwd_sel_e         sel_o
);
  logic hit_mem, hit_wb;
  assign hit_mem = src_rd_i && mem_ok_i && (mem_rd_i == src_i);
  assign hit_wb  = src_rd_i && wb_ok_i  && (wb_rd_i  == src_i);

  // younger producer first
  always_comb begin
    if (hit_mem)     sel_o = SEL_MEM;
    else if (hit_wb) sel_o = SEL_WB;
    else             sel_o = SEL_RF;
  end
endmodule

// File: rtl/hz_load_use.sv
module hz_load_use #(
  parameter int REG_W = 3
) (
  input  logic [REG_W-1:0] rs_i,
  input  logic             rs_rd_i,
  input  logic [REG_W-1:0] rt_i,
  input  logic             rt_rd_i,
  input  logic             rt_late_i,
  input  logic [REG_W-1:0] ld_rd_i,
  input  logic             ld_ok_i,
  output logic             stall_o
);
  logic rs_need, rt_need;
  assign rs_need = rs_rd_i && (rs_i == ld_rd_i);
  // store data is bypassed later from writeback
  assign rt_need = rt_rd_i && !rt_late_i && (rt_i == ld_rd_i);
  assign stall_o = ld_ok_i && (rs_need || rt_need);
endmodule

// File: rtl/hz_wt.sv
module hz_wt #(
  parameter int REG_W = 3,
  parameter int N_RD  = 2
) (
  input  logic [N_RD-1:0][REG_W-1:0] rd_idx_i,
  input  logic [N_RD-1:0]            rd_en_i,
  input  logic [REG_W-1:0]           wr_idx_i,
  input  logic                       wr_en_i,
  output logic [N_RD-1:0]            hit_o
);
  for (genvar g = 0; g < N_RD; g++) begin : g_port
    assign hit_o[g] = rd_en_i[g] && wr_en_i && (rd_idx_i[g] == wr_idx_i);
  end
endmodule

// File: rtl/hz_ctrl.sv
module hz_ctrl
  import hz_pkg::*;
#(
  parameter int REG_W = 3
) (
  input  logic [REG_W-1:0] dec_rs_i,
  input  logic             dec_rs_rd_i,
  input  logic [REG_W-1:0] dec_rt_i,
  input  logic             dec_rt_rd_i,
  input  logic             dec_rt_late_i,
  input  logic [REG_W-1:0] ex_rs_i,
  input  logic             ex_rs_rd_i,
  input  logic [REG_W-1:0] ex_rt_i,
  input  logic             ex_rt_rd_i,
  input  logic [REG_W-1:0] ex_rd_i,
  input  logic             ex_we_i,
  input  logic             ex_load_i,
  input  logic             ex_vld_i,
  input  logic [REG_W-1:0] mem_rd_i,
  input  logic             mem_we_i,
  input  logic             mem_load_i,
  input  logic             mem_vld_i,
  input  logic [REG_W-1:0] mem_st_src_i,
  input  logic             mem_st_rd_i,
  input  logic [REG_W-1:0] wb_rd_i,
  input  logic             wb_we_i,
  input  logic             wb_vld_i,
  output logic [1:0]       fwd_a_sel_o,
  output logic [1:0]       fwd_b_sel_o,
  output logic             st_data_fwd_o,
  output logic             wt_a_o,
  output logic             wt_b_o,
  output logic             stall_o,
  output logic             bubble_o
);
  localparam int NOPS = 2;

  logic mem_ok, wb_ok, ld_ok;
  assign mem_ok = mem_vld_i && mem_we_i && !mem_load_i;
  assign wb_ok  = wb_vld_i && wb_we_i;
  assign ld_ok  = ex_vld_i && ex_we_i && ex_load_i;

  logic [NOPS-1:0][REG_W-1:0] ex_src;
  logic [NOPS-1:0]            ex_src_rd;
  fwd_sel_e                   sel [NOPS];
  assign ex_src    = {ex_rt_i, ex_rs_i};
  assign ex_src_rd = {ex_rt_rd_i, ex_rs_rd_i};

  for (genvar g = 0; g < NOPS; g++) begin : g_op
    hz_src_fwd #(.REG_W(REG_W)) i_fwd (
      .src_i   (ex_src[g]),
      .src_rd_i(ex_src_rd[g]),
      .mem_ok_i(mem_ok),
      .mem_rd_i(mem_rd_i),
      .wb_ok_i (wb_ok),
      .wb_rd_i (wb_rd_i),
      .sel_o   (sel[g])
    );
  end
  assign fwd_a_sel_o = sel[0];
  assign fwd_b_sel_o = sel[1];

  assign st_data_fwd_o = mem_st_rd_i && wb_ok && (wb_rd_i == mem_st_src_i);

  logic [NOPS-1:0] wt_hit;
  hz_wt #(.REG_W(REG_W), .N_RD(NOPS)) i_wt (
    .rd_idx_i({dec_rt_i, dec_rs_i}),
    .rd_en_i ({dec_rt_rd_i, dec_rs_rd_i}),
    .wr_idx_i(wb_rd_i),
    .wr_en_i (wb_ok),
    .hit_o   (wt_hit)
  );
  assign wt_a_o = wt_hit[0];
  assign wt_b_o = wt_hit[1];

  logic stall;
  hz_load_use #(.REG_W(REG_W)) i_lu (
    .rs_i     (dec_rs_i),
    .rs_rd_i  (dec_rs_rd_i),
    .rt_i     (dec_rt_i),
    .rt_rd_i  (dec_rt_rd_i),
    .rt_late_i(dec_rt_late_i),
    .ld_rd_i  (ex_rd_i),
    .ld_ok_i  (ld_ok),
    .stall_o  (stall)
  );
  assign stall_o  = stall;
  assign bubble_o = stall;
endmodule

// File: rtl/hz_ctrl_chk.sv
module hz_ctrl_chk #(
  parameter int REG_W = 3
) (
  input logic [REG_W-1:0] dec_rs_i,
  input logic             dec_rs_rd_i,
  input logic [REG_W-1:0] dec_rt_i,
  input logic             dec_rt_rd_i,
  input logic             dec_rt_late_i,
  input logic [REG_W-1:0] ex_rs_i,
  input logic             ex_rs_rd_i,
  input logic [REG_W-1:0] ex_rt_i,
  input logic             ex_rt_rd_i,
  input logic [REG_W-1:0] ex_rd_i,
  input logic             ex_we_i,
  input logic             ex_load_i,
  input logic             ex_vld_i,
  input logic [REG_W-1:0] mem_rd_i,
  input logic             mem_we_i,
  input logic             mem_load_i,
  input logic             mem_vld_i,
  input logic [REG_W-1:0] mem_st_src_i,
  input logic             mem_st_rd_i,
  input logic [REG_W-1:0] wb_rd_i,
  input logic             wb_we_i,
  input logic             wb_vld_i,
  input logic [1:0]       fwd_a_sel_o,
  input logic [1:0]       fwd_b_sel_o,
  input logic             st_data_fwd_o,
  input logic             wt_a_o,
  input logic             wt_b_o,
  input logic             stall_o,
  input logic             bubble_o
);
  always_comb begin
    assert_sel_a_legal_R1: assert (fwd_a_sel_o != 2'd3) else $error("R1 illegal select");
    assert_sel_b_legal_R2: assert (fwd_b_sel_o != 2'd3) else $error("R2 illegal select");
    if (ex_rs_rd_i && mem_vld_i && mem_we_i && !mem_load_i && mem_rd_i == ex_rs_i)
      assert_mem_first_R3: assert (fwd_a_sel_o == 2'd1) else $error("R3 priority");
    if (!(mem_vld_i && mem_we_i) && !(wb_vld_i && wb_we_i))
      assert_no_squash_fwd_R4: assert (fwd_a_sel_o == 2'd0 && fwd_b_sel_o == 2'd0 && !st_data_fwd_o)
        else $error("R4 squashed forward");
    if (mem_load_i)
      assert_no_load_mx_R5: assert (fwd_a_sel_o != 2'd1 && fwd_b_sel_o != 2'd1) else $error("R5");
    if (st_data_fwd_o)
      assert_st_src_R6: assert (mem_st_rd_i && wb_vld_i && wb_we_i) else $error("R6");
    if (wt_a_o || wt_b_o)
      assert_wt_qual_R7: assert (wb_vld_i && wb_we_i) else $error("R7");
    if (stall_o)
      assert_stall_load_R8: assert (ex_vld_i && ex_we_i && ex_load_i) else $error("R8");
    if (!dec_rs_rd_i && !dec_rt_rd_i)
      assert_no_read_stall_R10: assert (!stall_o) else $error("R10");
    assert_bubble_R11: assert (bubble_o == stall_o) else $error("R11");
  end
endmodule

bind hz_ctrl hz_ctrl_chk #(.REG_W(REG_W)) i_chk (.*);

// File: tb/test_hz_ctrl.sv
module test_hz_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int RW = 3;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [RW-1:0] dec_rs, dec_rt, ex_rs, ex_rt, ex_rd, mem_rd, mem_st_src, wb_rd;
  logic dec_rs_rd, dec_rt_rd, dec_rt_late, ex_rs_rd, ex_rt_rd, ex_we, ex_load, ex_vld;
  logic mem_we, mem_load, mem_vld, mem_st_rd, wb_we, wb_vld;
  logic [1:0] fa, fb;
  logic sdf, wta, wtb, stall, bubble;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  hz_ctrl #(.REG_W(RW)) i_hz_ctrl (
    .dec_rs_i(dec_rs), .dec_rs_rd_i(dec_rs_rd), .dec_rt_i(dec_rt), .dec_rt_rd_i(dec_rt_rd),
    .dec_rt_late_i(dec_rt_late), .ex_rs_i(ex_rs), .ex_rs_rd_i(ex_rs_rd), .ex_rt_i(ex_rt),
    .ex_rt_rd_i(ex_rt_rd), .ex_rd_i(ex_rd), .ex_we_i(ex_we), .ex_load_i(ex_load),
    .ex_vld_i(ex_vld), .mem_rd_i(mem_rd), .mem_we_i(mem_we), .mem_load_i(mem_load),
    .mem_vld_i(mem_vld), .mem_st_src_i(mem_st_src), .mem_st_rd_i(mem_st_rd),
    .wb_rd_i(wb_rd), .wb_we_i(wb_we), .wb_vld_i(wb_vld),
    .fwd_a_sel_o(fa), .fwd_b_sel_o(fb), .st_data_fwd_o(sdf), .wt_a_o(wta), .wt_b_o(wtb),
    .stall_o(stall), .bubble_o(bubble)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic idle();
    {dec_rs, dec_rt, ex_rs, ex_rt, ex_rd, mem_rd, mem_st_src, wb_rd} = '0;
    {dec_rs_rd, dec_rt_rd, dec_rt_late, ex_rs_rd, ex_rt_rd, ex_we, ex_load, ex_vld} = '0;
    {mem_we, mem_load, mem_vld, mem_st_rd, wb_we, wb_vld} = '0;
  endtask

  // apply at posedge, sample at negedge
  task automatic settle();
    @(negedge clk);
  endtask

  task automatic t_reset_state();
    @(posedge clk); idle(); settle();
    chk("R1 idle sel_a", fa, 0);
    chk("R2 idle sel_b", fb, 0);
    chk("R7 idle wt", {wta, wtb}, 0);
    chk("R8 idle stall", stall, 0);
  endtask

  task automatic t_alu_chain();
    @(posedge clk); idle();
    ex_rs = 2; ex_rs_rd = 1; ex_rt = 2; ex_rt_rd = 1;
    mem_rd = 2; mem_we = 1; mem_vld = 1;
    settle();
    chk("R1 mem->ex a", fa, 1);
    chk("R2 mem->ex b", fb, 1);
    @(posedge clk); wb_rd = 2; wb_we = 1; wb_vld = 1; settle();
    chk("R3 mem over wb", fa, 1);
    @(posedge clk); mem_rd = 5; settle();
    chk("R1 wb->ex a", fa, 2);
    chk("R2 wb->ex b", fb, 2);
    @(posedge clk); ex_rt_rd = 0; settle();
    chk("R2 unread rt", fb, 0);
  endtask

  task automatic t_squashed();
    @(posedge clk); idle();
    ex_rs = 2; ex_rs_rd = 1;
    mem_rd = 2; mem_we = 1; mem_vld = 0;
    wb_rd = 2; wb_we = 0; wb_vld = 1;
    settle();
    chk("R4 squashed/no-write", fa, 0);
    @(posedge clk); mem_vld = 1; mem_we = 0; settle();
    chk("R4 mem no write", fa, 0);
  endtask

  task automatic t_mem_load();
    @(posedge clk); idle();
    ex_rs = 6; ex_rs_rd = 1;
    mem_rd = 6; mem_we = 1; mem_vld = 1; mem_load = 1;
    wb_rd = 6; wb_we = 1; wb_vld = 1;
    settle();
    chk("R5 load in mem skipped", fa, 2);
  endtask

  task automatic t_store_data();
    @(posedge clk); idle();
    mem_st_rd = 1; mem_st_src = 4; wb_rd = 4; wb_we = 1; wb_vld = 1;
    settle();
    chk("R6 wb->mem store data", sdf, 1);
    @(posedge clk); wb_vld = 0; settle();
    chk("R6 squashed wb", sdf, 0);
    @(posedge clk); wb_vld = 1; mem_st_src = 3; settle();
    chk("R6 other reg", sdf, 0);
  endtask

  task automatic t_write_through();
    @(posedge clk); idle();
    dec_rs = 3; dec_rs_rd = 1; dec_rt = 3; dec_rt_rd = 1;
    wb_rd = 3; wb_we = 1; wb_vld = 1;
    settle();
    chk("R7 wt rs", wta, 1);
    chk("R7 wt rt", wtb, 1);
    @(posedge clk); wb_we = 0; settle();
    chk("R7 no write enable", {wta, wtb}, 0);
  endtask

  task automatic t_load_use();
    @(posedge clk); idle();
    ex_rd = 1; ex_we = 1; ex_load = 1; ex_vld = 1;
    dec_rs = 1; dec_rs_rd = 1;
    settle();
    chk("R8 stall rs", stall, 1);
    chk("R11 bubble", bubble, 1);
    @(posedge clk); dec_rs_rd = 0; dec_rt = 1; dec_rt_rd = 1; settle();
    chk("R8 stall rt", stall, 1);
    // load moves on: ex now holds the bubble
    @(posedge clk); ex_vld = 0; ex_load = 0; mem_rd = 1; mem_we = 1; mem_vld = 1; mem_load = 1;
    settle();
    chk("R8 clears next cycle", stall, 0);
    chk("R11 bubble clears", bubble, 0);
    @(posedge clk); idle(); ex_rd = 1; ex_we = 1; ex_vld = 1; dec_rs = 1; dec_rs_rd = 1; settle();
    chk("R8 non-load no stall", stall, 0);
    @(posedge clk); ex_load = 1; ex_vld = 0; settle();
    chk("R8 squashed load", stall, 0);
  endtask

  task automatic t_load_store();
    @(posedge clk); idle();
    ex_rd = 1; ex_we = 1; ex_load = 1; ex_vld = 1;
    dec_rt = 1; dec_rt_rd = 1; dec_rt_late = 1; dec_rs = 5; dec_rs_rd = 1;
    settle();
    chk("R9 store data no stall", stall, 0);
    @(posedge clk); dec_rs = 1; settle();
    chk("R9 store address stalls", stall, 1);
  endtask

  task automatic t_no_read();
    @(posedge clk); idle();
    ex_rd = 7; ex_we = 1; ex_load = 1; ex_vld = 1;
    dec_rs = 7; dec_rt = 7;
    settle();
    chk("R10 jump bits match", stall, 0);
    chk("R11 no bubble", bubble, 0);
  endtask

  initial begin
    idle();
    t_reset_state();
    t_alu_chain();
    t_squashed();
    t_mem_load();
    t_store_data();
    t_write_through();
    t_load_use();
    t_load_store();
    t_no_read();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule